// File: doc/BRIEF.md
# Four-Channel Complementary Dead-Time and Pattern Generator

This block sits between a timer's compare outputs and eight output pins. Each of the four compare waveforms can drive a complementary pair: a high-side pin and a low-side pin. When a pair is enabled, the block inserts a programmable gap so the two pins are never high together. When a pair is not enabled, the raw waveform passes through to the high-side pin.

A common-drive mode feeds the first channel's waveform into all four gap generators. A pattern mode bypasses gap insertion and uses the two delay registers as an output mask and an output value. The mask and value are loaded on the timer's update strobe.

All pins are registered. Every path from a waveform or a control register to a pin adds one register stage at the pin.

Top module: `dtpg_top`

## Requirements
- R1: After synchronous reset, the control readback `ctrl_o` is 0x00 and all eight pins are low.
- R2: Control bits 7:6 are reserved and always read back as zero. A write sets bits 5:0 exactly as written. The readback changes at the clock edge that samples `ctrl_wr_i`.
- R3: For channel n, when control bit n is clear and control bit 5 is clear, `pin_o[n]` equals `wave_i[n]` one clock later and `pin_o[4+n]` is low.
- R4: When control bit n is set, the gap generator drives pair n: `pin_o[n]` is the high side and `pin_o[4+n]` is the low side. With both delay counts at zero, the pair is exactly complementary and switches two clocks after the input change.
- R5: On a rising input edge, the low-side pin drops two clocks after the change. The high-side pin rises `dt_hi_i` clocks later than that.
- R6: On a falling input edge, the high-side pin drops two clocks after the change. The low-side pin rises `dt_lo_i` clocks later than that.
- R7: If an input level lasts `dt_hi_i` clock cycles or fewer, the high side never asserts. If it lasts one cycle longer, the high side asserts for exactly one cycle, because a new edge wins over counter expiry.
- R8: The high-side and low-side pins of a channel driven by its gap generator are never high in the same cycle.
- R9: When control bit 4 is set, all four gap generators take `wave_i[0]`, and `wave_i[3:1]` are ignored.
- R10: When control bit 5 is set, each pin bit k is taken from a pattern if mask bit k is set, and from the raw path otherwise. Pin bits 3:0 are the high sides of channels 0 to 3; bits 7:4 are the low sides. The mask comes from `dt_lo_i` and the value from `dt_hi_i`. Both are captured only at a clock edge with `upd_i` high, and the pins show them one clock later.
- R11: Pattern mode overrides the channel enables. Unmasked bits of an enabled channel follow the raw path (high side = waveform, low side = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bits 3:0 enable, bit 4 common drive, bit 5 pattern mode |
| ctrl_o | output | 8 | Control register readback |
| dt_hi_i | input | 8 | High-side delay in clocks, or pattern value |
| dt_lo_i | input | 8 | Low-side delay in clocks, or pattern mask |
| wave_i | input | 4 | Timer compare waveforms, channels 0 to 3 |
| upd_i | input | 1 | Timer update strobe |
| pin_o | output | 8 | Pins: [3:0] high sides, [7:4] low sides |

## Verification
Inside one gap generator, the delay counter can expire in the same cycle that a new input edge arrives. The design gives the edge priority: the counter is reloaded and the pending side is dropped.

The bench provokes this collision with a pulse exactly `dt_hi_i` cycles long and counts high-side cycles on the pin; it expects none. It then repeats with a pulse one cycle longer and expects exactly one high cycle. This pins down the boundary from both sides.

// File: rtl/dtpg_pkg.sv
package dtpg_pkg;
  localparam int NCH    = 4;
  localparam int DT_W   = 8;
  localparam int CTRL_W = 8;
  localparam int NPIN   = 2 * NCH;
  localparam int CW_BIT  = NCH;
  localparam int PAT_BIT = NCH + 1;
endpackage

// File: rtl/dtpg_ctrl_reg.sv
module dtpg_ctrl_reg #(
  parameter int CTRL_W = 8,
  parameter int USED_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam logic [CTRL_W-1:0] KEEP = CTRL_W'((1 << USED_W) - 1);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)       ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i & KEEP;
  end

  assign ctrl_o = ctrl_q;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~KEEP) == '0);
endmodule

// File: rtl/dtpg_deadtime.sv
module dtpg_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            w_i,
  input  logic [DT_W-1:0] dly_hi_i,
  input  logic [DT_W-1:0] dly_lo_i,
  output logic            hs_o,
  output logic            ls_o
);
  logic            w_q;
  logic [DT_W-1:0] cnt_q;
  logic            hs_q, ls_q;
  logic            edge_w;
  logic [DT_W-1:0] dly;

  assign edge_w = w_i ^ w_q;
  assign dly    = w_i ? dly_hi_i : dly_lo_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= 1'b0;
      cnt_q <= '0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b1;
    end else begin
      w_q <= w_i;
      if (edge_w) begin
        hs_q  <= w_i && (dly == '0);
        ls_q  <= !w_i && (dly == '0);
        cnt_q <= dly;
      end else if (cnt_q == DT_W'(1)) begin
        cnt_q <= '0;
        hs_q  <= w_q;
        ls_q  <= !w_q;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - DT_W'(1);
      end
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));
  // R5
  rise_ls_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_w && w_i) |=> !ls_q);
  // R6
  fall_hs_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_w && !w_i) |=> !hs_q);
endmodule

// File: rtl/dtpg_pattern.sv
module dtpg_pattern #(
  parameter int DT_W = 8,
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_i,
  input  logic [DT_W-1:0] mask_src_i,
  input  logic [DT_W-1:0] val_src_i,
  output logic [NPIN-1:0] mask_o,
  output logic [NPIN-1:0] val_o
);
  logic [NPIN-1:0] mask_q, val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      val_q  <= '0;
    end else if (upd_i) begin
      mask_q <= mask_src_i[NPIN-1:0];
      val_q  <= val_src_i[NPIN-1:0];
    end
  end

  assign mask_o = mask_q;
  assign val_o  = val_q;

  // R10
  pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> ($stable(mask_q) && $stable(val_q)));
endmodule

// File: rtl/dtpg_top.sv
module dtpg_top
  import dtpg_pkg::*;
#(
  parameter int N  = NCH,
  parameter int DW = DT_W,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr_i,
  input  logic [CW-1:0] ctrl_wdata_i,
  output logic [CW-1:0] ctrl_o,
  input  logic [DW-1:0] dt_hi_i,
  input  logic [DW-1:0] dt_lo_i,
  input  logic [N-1:0]  wave_i,
  input  logic          upd_i,
  output logic [2*N-1:0] pin_o
);
  localparam int NP = 2 * N;
  localparam int CWB = N;
  localparam int PTB = N + 1;

  logic [CW-1:0] ctrl_q;
  logic [N-1:0]  gen_hs, gen_ls;
  logic [NP-1:0] pmask, pval;
  logic [NP-1:0] pin_d, pin_q;

  dtpg_ctrl_reg #(.CTRL_W(CW), .USED_W(N + 2)) u_ctrl (
    .clk(clk), .rst(rst), .wr_i(ctrl_wr_i), .wdata_i(ctrl_wdata_i), .ctrl_o(ctrl_q)
  );

  dtpg_pattern #(.DT_W(DW), .NPIN(NP)) u_pat (
    .clk(clk), .rst(rst), .upd_i(upd_i),
    .mask_src_i(dt_lo_i), .val_src_i(dt_hi_i),
    .mask_o(pmask), .val_o(pval)
  );

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic w_sel;
    assign w_sel = ctrl_q[CWB] ? wave_i[0] : wave_i[c];

    dtpg_deadtime #(.DT_W(DW)) u_dt (
      .clk(clk), .rst(rst), .w_i(w_sel),
      .dly_hi_i(dt_hi_i), .dly_lo_i(dt_lo_i),
      .hs_o(gen_hs[c]), .ls_o(gen_ls[c])
    );

    always_comb begin
      if (ctrl_q[PTB]) begin
        pin_d[c]   = pmask[c]   ? pval[c]   : wave_i[c];
        pin_d[N+c] = pmask[N+c] ? pval[N+c] : 1'b0;
      end else if (ctrl_q[c]) begin
        pin_d[c]   = gen_hs[c];
        pin_d[N+c] = gen_ls[c];
      end else begin
        pin_d[c]   = wave_i[c];
        pin_d[N+c] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_d;
  end

  assign pin_o  = pin_q;
  assign ctrl_o = ctrl_q;

  // R1
  reset_pins_chk: assert property (@(posedge clk)
    $past(rst) |-> (pin_q == '0));
  // R3
  raw_path_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[PTB] && !ctrl_q[0]) |=> (pin_q[0] == $past(wave_i[0]) && !pin_q[N]));
endmodule

// File: tb/dtpg_top_tb.sv
module dtpg_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_o;
  logic [7:0] dt_hi = '0, dt_lo = '0;
  logic [3:0] wave = '0;
  logic       upd = 1'b0;
  logic [7:0] pin;

  int vectors = 0;
  int miscompares = 0;
  int overlaps = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtpg_top u_dut (
    .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_o(ctrl_o), .dt_hi_i(dt_hi), .dt_lo_i(dt_lo), .wave_i(wave),
    .upd_i(upd), .pin_o(pin)
  );

  // R8 monitor: generator-driven pairs never both high
  always @(negedge clk) begin
    if (!rst && !ctrl_o[5]) begin
      for (int c = 0; c < 4; c++)
        if (ctrl_o[c] && pin[c] && pin[4+c]) overlaps++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    step(1);
    ctrl_wr = 1'b0;
  endtask

  task automatic pulse_upd();
    upd = 1'b1; step(1); upd = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3); rst = 1'b0;
    chk("R1 ctrl", ctrl_o, 8'h00);
    chk("R1 pins", pin, 8'h00);
  endtask

  task automatic t_reserved();
    wr_ctrl(8'hFF);
    chk("R2 reserved", ctrl_o, 8'h3F);
    wr_ctrl(8'h00);
    chk("R2 clear", ctrl_o, 8'h00);
  endtask

  task automatic t_raw();
    wave = 4'b1010; step(1);
    chk("R3 raw", pin, 8'h0A);
    wave = 4'b0101; step(1);
    chk("R3 raw2", pin, 8'h05);
    wave = 4'b0000; step(2);
  endtask

  task automatic t_zero_dt();
    dt_hi = 0; dt_lo = 0;
    wr_ctrl(8'h01); step(4);
    chk("R4 idle low side", pin, 8'h10);
    wave[0] = 1'b1; step(1);
    chk("R4 not yet", pin, 8'h10);
    step(1);
    chk("R4 complementary", pin, 8'h01);
    wave[0] = 1'b0; step(2);
    chk("R4 back", pin, 8'h10);
  endtask

  task automatic t_rise_fall();
    dt_hi = 3; dt_lo = 2; step(2);
    wave[0] = 1'b1; step(2);
    chk("R5 ls dropped", pin, 8'h00);
    step(2);
    chk("R5 gap held", pin, 8'h00);
    step(1);
    chk("R5 hs up", pin, 8'h01);
    wave[0] = 1'b0; step(2);
    chk("R6 hs dropped", pin, 8'h00);
    step(1);
    chk("R6 gap held", pin, 8'h00);
    step(1);
    chk("R6 ls up", pin, 8'h10);
  endtask

  task automatic t_short_pulse();
    int highs;
    dt_hi = 4; dt_lo = 0; step(3);
    highs = 0;
    wave[0] = 1'b1;
    for (int i = 0; i < 4; i++) begin step(1); highs += pin[0]; end
    wave[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin step(1); highs += pin[0]; end
    chk("R7 width=dt never high", 8'(highs), 8'd0);
    highs = 0;
    wave[0] = 1'b1;
    for (int i = 0; i < 5; i++) begin step(1); highs += pin[0]; end
    wave[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin step(1); highs += pin[0]; end
    chk("R7 width=dt+1 one cycle", 8'(highs), 8'd1);
  endtask

  task automatic t_common();
    dt_hi = 0; dt_lo = 0;
    wr_ctrl(8'h1F);
    wave = 4'b0001; step(4);
    chk("R9 all follow ch0 high", pin, 8'h0F);
    wave = 4'b1110; step(4);
    chk("R9 all follow ch0 low", pin, 8'hF0);
    chk("R8 no overlap seen", 8'(overlaps), 8'd0);
  endtask

  task automatic t_pattern();
    wr_ctrl(8'h20);
    dt_lo = 8'h07; dt_hi = 8'h05; wave = 4'b1000; step(3);
    chk("R10 before update", pin, 8'h08);
    pulse_upd(); step(1);
    chk("R10 after update", pin, 8'h0D);
    dt_hi = 8'hFF; step(3);
    chk("R10 held without update", pin, 8'h0D);
  endtask

  task automatic t_override();
    wr_ctrl(8'h2F);
    dt_lo = 8'h00; dt_hi = 8'h00;
    pulse_upd();
    wave = 4'b0011; step(3);
    chk("R11 enables overridden", pin, 8'h03);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_reserved();
    t_raw();
    t_zero_dt();
    t_rise_fall();
    t_short_pulse();
    t_common();
    t_pattern();
    t_override();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule